// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level page table held in an external table memory. The page size is 4 KiB, so the low 12 address bits are the page offset and are never translated. Only 31 virtual address bits are meaningful. The 19-bit virtual page number is split into a 9-bit first-level index and a 10-bit second-level index. The two parts feed two dependent table reads.

A requester raises a request together with a virtual address. The walker accepts it only while it is idle. It reads the first-level entry, which names the second-level table. If that entry is valid, it reads the second-level entry, which holds the physical page number. It then returns a one-cycle response carrying either a 27-bit physical address or a fault flag. The block does not load tables and does not resolve page faults; it only reports them. The table memory is a simple synchronous read port: an address presented with a read enable returns its word one cycle later.

Top module: `ptw_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_rd_en is 0. req_ready is 1 only while the walker is idle, and a request is accepted on a clock edge where req_valid and req_ready are both 1.
- R2: In the accepting cycle the walker reads the table memory (mem_rd_en = 1) at word address vaddr[30:22], zero-extended to 16 bits. The first-level table therefore occupies words 0 to 511.
- R3: A table word has its valid flag in bit 15. In a first-level word, bits 5:0 select the second-level table. When the first-level word is valid, the walker reads word {bits 5:0, vaddr[21:12]} in the cycle after the first read.
- R4: When the first-level word is invalid, no second read is made. The response arrives 2 cycles after the accepting edge with rsp_fault = 1.
- R5: When both words are valid, the response arrives 3 cycles after the accepting edge with rsp_fault = 0. rsp_paddr is {second-level bits 14:0, vaddr[11:0]}, so the low 12 bits of the address are copied unchanged.
- R6: When the first-level word is valid and the second-level word is invalid, the response arrives 3 cycles after the accepting edge with rsp_fault = 1.
- R7: rsp_valid is high for exactly one cycle per accepted request, and rsp_paddr is 0 whenever rsp_fault is 1.
- R8: Bit 31 of req_vaddr has no effect on table addresses, fault or physical address.
- R9: While a walk is in progress, req_valid and req_vaddr are ignored. The response reflects the address that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address, bit 31 ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Page not resident at either level |
| rsp_paddr | output | 27 | Physical address, zero on fault |
| mem_rd_en | output | 1 | Table memory read enable |
| mem_addr | output | 16 | Table memory word address |
| mem_rdata | input | 16 | Table word, valid the cycle after the read |

## Verification
The bench goes after the fault split between the two levels. A walker that ignored the first-level valid flag would make a second read and answer a cycle late, so the bench counts memory reads and the response latency for every walk. It drives addresses with bit 31 set and cleared and holds req_valid with a changing address during a walk. A design that decoded bit 31 or re-latched the address while busy would read the wrong entries and return a wrong page. The bench also uses all-ones and all-zero addresses, maximum page numbers and invalid entries carrying garbage payloads. These catch a design that swapped index fields or leaked a page number into a faulting response.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W    = 32;
    localparam int VA_USED = 31;
    localparam int OFF_W   = 12;
    localparam int L1_W    = 9;
    localparam int L2_W    = 10;
    localparam int PPN_W   = 15;
    localparam int PA_W    = PPN_W + OFF_W;
    localparam int MEM_AW  = 16;
    localparam int MEM_DW  = PPN_W + 1;
    localparam int TSEL_W  = MEM_AW - L2_W;

    typedef struct packed {
        logic [L1_W-1:0]  l1;
        logic [L2_W-1:0]  l2;
        logic [OFF_W-1:0] off;
    } va_fields_t;

    typedef struct packed {
        logic [L2_W-1:0]  l2;
        logic [OFF_W-1:0] off;
    } va_low_t;

    typedef struct packed {
        logic             v;
        logic [PPN_W-1:0] payload;
    } pte_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_L1,
        S_READ_L2,
        S_DONE,
        S_FAULT
    } walk_st_t;

    function automatic logic [MEM_AW-1:0] l1_word(input logic [L1_W-1:0] idx);
        return {{(MEM_AW-L1_W){1'b0}}, idx};
    endfunction

    function automatic logic [MEM_AW-1:0] l2_word(input pte_t e, input logic [L2_W-1:0] idx);
        return {e.payload[TSEL_W-1:0], idx};
    endfunction

endpackage

// File: rtl/ptw_va_latch.sv
module ptw_va_latch
    import ptw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  va_low_t va_in,
    output va_low_t va_q
);
    always_ff @(posedge clk) begin
        if (rst)       va_q <= '0;
        else if (load) va_q <= va_in;
    end
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [L1_W-1:0]   l1_idx,
    input  logic [L2_W-1:0]   l2_idx_q,
    input  logic [MEM_DW-1:0] mem_rdata,
    output logic              req_ready,
    output logic              accept,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              set_ok,
    output logic              set_fault,
    output logic [PPN_W-1:0]  ppn
);
    walk_st_t st, st_nxt;
    pte_t     ent;

    assign ent       = pte_t'(mem_rdata);
    assign ppn       = ent.payload;
    assign req_ready = (st == S_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        st_nxt    = st;
        mem_rd_en = 1'b0;
        mem_addr  = '0;
        set_ok    = 1'b0;
        set_fault = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (req_valid) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = l1_word(l1_idx);
                    st_nxt    = S_READ_L1;
                end
            end
            S_READ_L1: begin
                if (ent.v) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = l2_word(ent, l2_idx_q);
                    st_nxt    = S_READ_L2;
                end else begin
                    set_fault = 1'b1;
                    st_nxt    = S_FAULT;
                end
            end
            S_READ_L2: begin
                if (ent.v) begin
                    set_ok = 1'b1;
                    st_nxt = S_DONE;
                end else begin
                    set_fault = 1'b1;
                    st_nxt    = S_FAULT;
                end
            end
            S_DONE, S_FAULT: st_nxt = S_IDLE;
            default:         st_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= st_nxt;
    end
endmodule

// File: rtl/ptw_rsp_build.sv
module ptw_rsp_build
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_ok,
    input  logic             set_fault,
    input  logic [PPN_W-1:0] ppn,
    input  logic [OFF_W-1:0] off,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= set_ok || set_fault;
            rsp_fault <= set_fault;
            rsp_paddr <= set_ok ? {ppn, off} : '0;
        end
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [MEM_DW-1:0] mem_rdata
);
    va_fields_t       va_f;
    va_low_t          va_lo_in;
    va_low_t          va_lo_q;
    logic             accept;
    logic             set_ok;
    logic             set_fault;
    logic [PPN_W-1:0] ppn;

    assign va_f     = va_fields_t'(req_vaddr[VA_USED-1:0]);
    assign va_lo_in = '{l2: va_f.l2, off: va_f.off};

    ptw_va_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .va_in (va_lo_in),
        .va_q  (va_lo_q)
    );

    ptw_walk_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .l1_idx    (va_f.l1),
        .l2_idx_q  (va_lo_q.l2),
        .mem_rdata (mem_rdata),
        .req_ready (req_ready),
        .accept    (accept),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .set_ok    (set_ok),
        .set_fault (set_fault),
        .ppn       (ppn)
    );

    ptw_rsp_build u_rsp (
        .clk       (clk),
        .rst       (rst),
        .set_ok    (set_ok),
        .set_fault (set_fault),
        .ppn       (ppn),
        .off       (va_lo_q.off),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_paddr (rsp_paddr)
    );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              mem_rd_en,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [MEM_DW-1:0] mem_rdata
);
    logic [VA_W-1:0] va_masked;
    assign va_masked = req_vaddr & {1'b0, {(VA_W-1){1'b1}}};

    a_r2_first_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> (mem_rd_en && mem_addr == MEM_AW'(va_masked >> (VA_USED - L1_W))));

    a_r4_no_second_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!mem_rdata[MEM_DW-1] -> !mem_rd_en));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r7_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    a_r5_two_reads_before_ok: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> ($past(mem_rd_en, 2) && !$past(mem_rd_en)));
endmodule

bind ptw_top ptw_checker u_ptw_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata)
);

// File: tb/ptw_top_bench.sv
module ptw_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [26:0] rsp_paddr;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;

    logic [15:0] tbl [int];
    int          rd_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          ended = 1'b0;

    always #5 clk = ~clk;

    ptw_top u_ptw_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= tbl.exists(int'(mem_addr)) ? tbl[int'(mem_addr)] : 16'h0;
            rd_cnt    <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_tbl(input int a);
        return tbl.exists(a) ? tbl[a] : 16'h0;
    endfunction

    // reference walk from the requirements
    function automatic void ref_walk(input logic [31:0] va, output bit flt,
                                     output logic [26:0] pa, output int lat, output int nrd);
        logic [15:0] e1, e2;
        e1 = rd_tbl(int'(va[30:22]));
        if (!e1[15]) begin
            flt = 1; pa = '0; lat = 2; nrd = 1;
            return;
        end
        e2 = rd_tbl(int'({e1[5:0], va[21:12]}));
        nrd = 2; lat = 3;
        if (!e2[15]) begin flt = 1; pa = '0; end
        else begin flt = 0; pa = {e2[14:0], va[11:0]}; end
    endfunction

    // kind: 0 first-level invalid, 1 second-level invalid, 2 valid
    task automatic setup(input logic [31:0] va, input int kind, input logic [14:0] ppn);
        logic [5:0] sel;
        sel = 6'(1 + ($urandom % 63));
        if (kind == 0) tbl[int'(va[30:22])] = {1'b0, 15'($urandom)};
        else begin
            tbl[int'(va[30:22])] = {1'b0, 9'($urandom), sel} | 16'h8000;
            tbl[int'({sel, va[21:12]})] = (kind == 1) ? {1'b0, 15'($urandom)} : {1'b1, ppn};
        end
    endtask

    task automatic run(input logic [31:0] va, input bit hold, input string tag);
        bit flt; logic [26:0] pa; int lat, nrd, rd0, k;
        ref_walk(va, flt, pa, lat, nrd);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; rd0 = rd_cnt;
        @(negedge clk);
        chk(req_ready == 1'b0, {tag, " R1 ready low while busy"}, req_ready, 0);
        if (hold) req_vaddr = ~va;   // R9: ignored while busy
        else req_valid = 1'b0;
        k = 1;
        while (!rsp_valid && k < 6) begin
            @(negedge clk);
            k++;
        end
        req_valid = 1'b0;
        chk(k == lat, {tag, " R4/R5/R6 latency"}, k, lat);
        chk(rsp_fault == flt, {tag, " R4/R6 fault"}, rsp_fault, flt);
        chk(rsp_paddr == pa, {tag, " R5/R7 paddr"}, rsp_paddr, pa);
        chk(rd_cnt - rd0 == nrd, {tag, " R3/R4 read count"}, rd_cnt - rd0, nrd);
        @(negedge clk);
        chk(rsp_valid == 1'b0, {tag, " R7 one-cycle pulse"}, rsp_valid, 0);
        chk(req_ready == 1'b1, {tag, " R1 idle again"}, req_ready, 1);
    endtask

    initial begin
        logic [31:0] va;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
        chk(mem_rd_en == 1'b0, "R1 reset rd_en", mem_rd_en, 0);
        rst = 1'b0;

        setup(32'h0, 2, 15'h7FFF);            run(32'h0, 0, "R5 zero va");
        setup(32'hFFFF_FFFF, 2, 15'h0001);    run(32'hFFFF_FFFF, 0, "R8 all ones");
        setup(32'h0040_1ABC, 0, 15'h0);       run(32'h0040_1ABC, 0, "R4 l1 fault");
        setup(32'h1234_5678, 1, 15'h0);       run(32'h1234_5678, 0, "R6 l2 fault");
        setup(32'h2ACE_F00D, 2, 15'h5A5A);    run(32'h2ACE_F00D, 1, "R9 held busy");
        setup(32'h3000_3FFF, 2, 15'h1234);
        run(32'h3000_3FFF, 0, "R8 bit31 clear");
        run(32'hB000_3FFF, 0, "R8 bit31 set");
        setup(32'h0FFF_F123, 2, 15'h4321);    run(32'h0FFF_F123, 0, "R2 R3 max l2 idx");

        for (int i = 0; i < 300; i++) begin
            va = $urandom;
            setup(va, ($urandom % 8 == 0) ? 0 : (($urandom % 6 == 0) ? 1 : 2), 15'($urandom));
            run(va, ($urandom % 5 == 0), "random");
        end

        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule